// File: doc/BRIEF.md
# ATM Idle Cell Header Filter

This block sits in a receive cell path and removes idle cells from a byte-wide ATM cell stream. Each 53-byte cell arrives one byte per accepted transfer, and its first byte is flagged by a start-of-cell strobe. The first four header bytes are held back while the block decides whether the cell is idle. Each header byte is compared with its own programmable pattern. A per-bit mask selects which bits take part in the comparison. A cell counts as idle only when all four bytes agree under their masks.

A discard enable in the configuration register controls idle cells. When it is set, a detected idle cell is swallowed whole and a one-cycle pulse flags it for an external counter. When it is clear, the cell is forwarded unchanged to the next stage. Non-idle cells are always forwarded intact. Both stream sides use valid/ready handshaking. Pattern, mask and enable values are sampled once per cell when its start byte is accepted, so a write never changes how a cell is handled after that cell has started.

Top module: `idle_cell_gate`

## Requirements
- R1: After reset every register reads 0, out_valid is low, and the block hunts for a start-of-cell byte.
- R2: The configuration register is at 0x4C. Bit 4 is the idle-discard enable, bits 6..0 read back what was written, and bit 7 always reads 0. The patterns for header bytes 1..4 are at 0x50..0x53 and their masks are at 0x54..0x57. Any other address reads 0.
- R3: A header bit is compared with its pattern bit only where the mask bit is 1; a mask bit of 0 makes it a don't-care. For example, header 0xA5 with mask 0xF0 and pattern 0xAD matches.
- R4: A cell is idle only when all four header bytes match. Byte 5 and the 48 payload bytes have no effect on the decision.
- R5: With the discard enable at 1, an idle cell produces no output bytes and no out_sop.
- R6: With the discard enable at 0, idle cells are forwarded unchanged.
- R7: A forwarded cell leaves as its 53 input bytes in the same order, with out_sop high on the first byte only.
- R8: idle_drop is high for exactly one cycle per discarded cell, in the cycle after the fourth header byte is accepted.
- R9: While hunting, bytes without in_sop are consumed and dropped. Inside a cell, in_sop is ignored.
- R10: Pattern, mask and enable values are taken when a cell's start byte is accepted. A write during a cell affects only later cells.
- R11: While the buffered header is being emitted, in_ready is low. After the header, in_ready follows out_ready and bytes pass straight through, so backpressure loses no byte and keeps the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is first byte of a cell |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is first byte of a cell |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the output byte |
| idle_drop | output | 1 | One-cycle pulse per discarded idle cell |

## Verification
Register reads and the stream outputs are combinational, so the bench samples them in the same cycle that drives them. It samples 1 ns after the driving falling edge, and in that cycle any output byte is compared with the head of the reference queue. A forwarded header appears only in the cycles after its fourth byte is accepted, so the reference model queues the header only at that point and leaves the byte order to the queue. idle_drop comes from a register. The model therefore arms its expected pulse after checking the current cycle, and that pulse is due exactly one sample later.

// File: rtl/icf_pkg.sv
package icf_pkg;
    typedef enum logic [2:0] {
        FS_HUNT,
        FS_HDR,
        FS_EMIT,
        FS_PASS,
        FS_DROP
    } flow_state_e;
endpackage

// File: rtl/icf_regs.sv
module icf_regs #(
    parameter int unsigned DW       = 8,
    parameter int unsigned NB       = 4,
    parameter int unsigned AW       = 8,
    parameter int unsigned DISC_BIT = 4,
    parameter logic [AW-1:0] CFG_ADDR = 'h4C,
    parameter logic [AW-1:0] PAT_BASE = 'h50,
    parameter logic [AW-1:0] MSK_BASE = 'h54
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [AW-1:0]          reg_addr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic                   snap,
    output logic [NB-1:0][DW-1:0]  act_pat,
    output logic [NB-1:0][DW-1:0]  act_msk,
    output logic                   act_disc
);
    localparam int unsigned CFG_W = DW - 1;

    typedef struct packed {
        logic [CFG_W-1:0]         cfg;
        logic [NB-1:0][DW-1:0]    pat;
        logic [NB-1:0][DW-1:0]    msk;
        logic [NB-1:0][DW-1:0]    a_pat;
        logic [NB-1:0][DW-1:0]    a_msk;
        logic                     a_disc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // snapshot uses the values held before any write of this cycle
        if (snap) begin
            r_d.a_pat  = r_q.pat;
            r_d.a_msk  = r_q.msk;
            r_d.a_disc = r_q.cfg[DISC_BIT];
        end
        if (reg_we) begin
            if (reg_addr == CFG_ADDR) begin
                r_d.cfg = reg_wdata[CFG_W-1:0];
            end
            for (int i = 0; i < NB; i++) begin
                if (reg_addr == PAT_BASE + AW'(i)) r_d.pat[i] = reg_wdata;
                if (reg_addr == MSK_BASE + AW'(i)) r_d.msk[i] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CFG_ADDR) reg_rdata = DW'(r_q.cfg);
        for (int i = 0; i < NB; i++) begin
            if (reg_addr == PAT_BASE + AW'(i)) reg_rdata = r_q.pat[i];
            if (reg_addr == MSK_BASE + AW'(i)) reg_rdata = r_q.msk[i];
        end
    end

    assign act_pat  = r_q.a_pat;
    assign act_msk  = r_q.a_msk;
    assign act_disc = r_q.a_disc;
endmodule

// File: rtl/icf_match.sv
module icf_match #(
    parameter int unsigned DW = 8,
    parameter int unsigned NB = 4
) (
    input  logic [NB-1:0][DW-1:0] hdr,
    input  logic [NB-1:0][DW-1:0] pat,
    input  logic [NB-1:0][DW-1:0] msk,
    output logic                  hit
);
    logic [NB-1:0] byte_ok;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign byte_ok[g] = ~|((hdr[g] ^ pat[g]) & msk[g]);
    end

    assign hit = &byte_ok;
endmodule

// File: rtl/icf_flow.sv
module icf_flow
    import icf_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned NB   = 4,
    parameter int unsigned CELL = 53
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic [DW-1:0]         in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic [DW-1:0]         out_data,
    input  logic                  out_ready,
    input  logic                  hit,
    input  logic                  disc,
    output logic                  snap,
    output logic [NB-1:0][DW-1:0] hdr_cmp,
    output logic                  idle_drop
);
    localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;
    localparam int unsigned CW = $clog2(CELL + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(CELL - 1);
    localparam logic [CW-1:0] HDR_CNT  = CW'(NB);

    typedef struct packed {
        flow_state_e            st;
        logic [IW-1:0]          idx;
        logic [CW-1:0]          cnt;
        logic [NB-1:0][DW-1:0]  hold;
        logic                   pulse;
    } flow_t;

    flow_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.pulse = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_data  = '0;
        snap      = 1'b0;
        unique case (f_q.st)
            FS_HUNT: begin
                in_ready = 1'b1;
                if (in_valid && in_sop) begin
                    f_d.hold[0] = in_data;
                    f_d.idx     = IW'(1);
                    f_d.st      = FS_HDR;
                    snap        = 1'b1;
                end
            end
            FS_HDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    f_d.hold[f_q.idx] = in_data;
                    if (f_q.idx == LAST_IDX) begin
                        f_d.cnt = HDR_CNT;
                        f_d.idx = '0;
                        if (hit && disc) begin
                            f_d.st    = FS_DROP;
                            f_d.pulse = 1'b1;
                        end else begin
                            f_d.st = FS_EMIT;
                        end
                    end else begin
                        f_d.idx = f_q.idx + IW'(1);
                    end
                end
            end
            FS_EMIT: begin
                out_valid = 1'b1;
                out_data  = f_q.hold[f_q.idx];
                out_sop   = (f_q.idx == '0);
                if (out_ready) begin
                    if (f_q.idx == LAST_IDX) f_d.st = FS_PASS;
                    else                     f_d.idx = f_q.idx + IW'(1);
                end
            end
            FS_PASS: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    f_d.cnt = f_q.cnt + CW'(1);
                    if (f_q.cnt == LAST_CNT) f_d.st = FS_HUNT;
                end
            end
            FS_DROP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    f_d.cnt = f_q.cnt + CW'(1);
                    if (f_q.cnt == LAST_CNT) f_d.st = FS_HUNT;
                end
            end
            default: f_d.st = FS_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // last header byte is compared live while the first ones come from the hold buffer
    always_comb begin
        hdr_cmp         = f_q.hold;
        hdr_cmp[NB-1]   = in_data;
    end

    assign idle_drop = f_q.pulse;
endmodule

// File: rtl/idle_cell_gate.sv
module idle_cell_gate #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned HDR_BYTES  = 4,
    parameter int unsigned CELL_BYTES = 53,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DISC_BIT   = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h4C,
    parameter logic [ADDR_W-1:0] PAT_BASE = 'h50,
    parameter logic [ADDR_W-1:0] MSK_BASE = 'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              idle_drop
);
    logic                             snap;
    logic                             hit;
    logic                             act_disc;
    logic [HDR_BYTES-1:0][DATA_W-1:0] act_pat;
    logic [HDR_BYTES-1:0][DATA_W-1:0] act_msk;
    logic [HDR_BYTES-1:0][DATA_W-1:0] hdr_cmp;

    icf_regs #(
        .DW(DATA_W), .NB(HDR_BYTES), .AW(ADDR_W), .DISC_BIT(DISC_BIT),
        .CFG_ADDR(CFG_ADDR), .PAT_BASE(PAT_BASE), .MSK_BASE(MSK_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snap(snap),
        .act_pat(act_pat), .act_msk(act_msk), .act_disc(act_disc)
    );

    icf_match #(.DW(DATA_W), .NB(HDR_BYTES)) u_match (
        .hdr(hdr_cmp), .pat(act_pat), .msk(act_msk), .hit(hit)
    );

    icf_flow #(.DW(DATA_W), .NB(HDR_BYTES), .CELL(CELL_BYTES)) u_flow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_sop(out_sop), .out_data(out_data), .out_ready(out_ready),
        .hit(hit), .disc(act_disc), .snap(snap), .hdr_cmp(hdr_cmp),
        .idle_drop(idle_drop)
    );
endmodule

// File: rtl/icf_chk.sv
module icf_chk #(
    parameter int unsigned NB   = 4,
    parameter int unsigned CELL = 53,
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] CFG_ADDR = 'h4C
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_sop,
    input logic          idle_drop,
    input logic [AW-1:0] reg_addr,
    input logic          cfg_ro_bit
);
    localparam int unsigned OW = $clog2(CELL);

    logic [OW-1:0] ocnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt <= '0;
        end else if (out_valid && out_ready) begin
            ocnt <= (ocnt == OW'(CELL - 1)) ? '0 : ocnt + OW'(1);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_drop |=> !idle_drop); // R8
    AST_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        idle_drop |-> !out_valid); // R5
    AST_SOP_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (out_sop == (ocnt == '0))); // R7
    AST_HDR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> !in_ready); // R11
    AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ocnt >= OW'(NB)) |-> (in_ready == out_ready)); // R11
    AST_RO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CFG_ADDR) |-> !cfg_ro_bit); // R2
endmodule

bind idle_cell_gate icf_chk #(
    .NB(HDR_BYTES), .CELL(CELL_BYTES), .AW(ADDR_W), .CFG_ADDR(CFG_ADDR)
) u_icf_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .idle_drop(idle_drop),
    .reg_addr(reg_addr), .cfg_ro_bit(reg_rdata[DATA_W-1])
);

// File: tb/test_idle_cell_gate.sv
`timescale 1ns/1ps
module test_idle_cell_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic       out_sop;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       idle_drop;

    always #2.5 clk = ~clk;

    idle_cell_gate i_idle_cell_gate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_sop(in_sop), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
        .out_ready(out_ready), .idle_drop(idle_drop)
    );

    int nchk = 0;
    int nfail = 0;

    // stimulus and reference state
    logic [8:0] inq[$];
    logic [8:0] expq[$];
    logic [7:0] sh_cfg = 8'h00;
    logic [7:0] sh_pat[4] = '{default: 8'h00};
    logic [7:0] sh_msk[4] = '{default: 8'h00};
    logic [7:0] m_pat[4];
    logic [7:0] m_msk[4];
    logic [7:0] m_hdr[4];
    bit   m_disc, m_in, m_drop, exp_pulse, bp_on;
    int   m_cnt;
    bit   wr_pend, wr_now;
    logic [7:0] wr_a, wr_v;
    int   acc_n, trig_at;
    logic [7:0] trig_a, trig_v;
    int   outs, drops;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_byte(input logic [8:0] b);
        logic sop;
        logic [7:0] d;
        bit idle;
        {sop, d} = b;
        if (!m_in) begin
            if (sop) begin
                m_in = 1; m_cnt = 1; m_hdr[0] = d;
                for (int i = 0; i < 4; i++) begin m_pat[i] = sh_pat[i]; m_msk[i] = sh_msk[i]; end
                m_disc = sh_cfg[4];
            end
        end else if (m_cnt < 4) begin
            m_hdr[m_cnt] = d;
            m_cnt++;
            if (m_cnt == 4) begin
                idle = 1;
                for (int i = 0; i < 4; i++)
                    if (((m_hdr[i] ^ m_pat[i]) & m_msk[i]) != 8'h00) idle = 0;
                m_drop = idle && m_disc;
                if (m_drop) exp_pulse = 1;
                else for (int i = 0; i < 4; i++) expq.push_back({(i == 0), m_hdr[i]});
            end
        end else begin
            if (!m_drop) expq.push_back({1'b0, d});
            m_cnt++;
            if (m_cnt == 53) m_in = 0;
        end
    endtask

    task automatic step();
        logic [8:0] e;
        @(negedge clk);
        if (inq.size() > 0 && $urandom_range(3) != 0) begin
            in_valid = 1'b1;
            {in_sop, in_data} = inq[0];
        end else begin
            in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h00;
        end
        out_ready = bp_on ? ($urandom_range(2) != 0) : 1'b1;
        wr_now = wr_pend;
        reg_we = wr_pend; reg_addr = wr_a; reg_wdata = wr_v;
        wr_pend = 0;
        #1;
        check(idle_drop === exp_pulse, "R8 idle_drop timing", idle_drop, exp_pulse);
        exp_pulse = 0;
        if (idle_drop) drops++;
        if (in_valid && in_ready) begin
            model_byte(inq.pop_front());
            acc_n++;
            if (acc_n == trig_at) begin wr_pend = 1; wr_a = trig_a; wr_v = trig_v; end
        end
        if (out_valid && out_ready) begin
            outs++;
            if (expq.size() == 0) begin
                check(0, "R5 unexpected output byte", {out_sop, out_data}, 0);
            end else begin
                e = expq.pop_front();
                check({out_sop, out_data} === e, "R7 output stream", {out_sop, out_data}, e);
            end
        end
        if (wr_now) begin
            if (wr_a == 8'h4C) sh_cfg = {1'b0, wr_v[6:0]};
            for (int i = 0; i < 4; i++) begin
                if (wr_a == 8'h50 + i) sh_pat[i] = wr_v;
                if (wr_a == 8'h54 + i) sh_msk[i] = wr_v;
            end
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
        wr_pend = 1; wr_a = a; wr_v = v;
        step();
    endtask

    task automatic reg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0; reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic add_cell(input logic [31:0] h, input int seed, input int extra_sop);
        for (int k = 0; k < 53; k++) begin
            logic [7:0] b;
            b = (k < 4) ? h[31 - 8*k -: 8] : 8'((k * 13 + seed) & 255);
            inq.push_back({(k == 0) || (k == extra_sop), b});
        end
    endtask

    task automatic run_batch(input int exp_out, input int exp_drops, input string tag);
        int guard;
        outs = 0; drops = 0; acc_n = 0; guard = 0;
        while ((inq.size() > 0 || expq.size() > 0) && guard < 5000) begin
            step();
            guard++;
        end
        for (int i = 0; i < 3; i++) step();
        trig_at = -1;
        check(outs == exp_out, {tag, " output byte count"}, outs, exp_out);
        check(drops == exp_drops, {tag, " discarded cell count"}, drops, exp_drops);
    endtask

    initial begin
        trig_at = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready === 1'b1, "R1 hunting after reset", in_ready, 1);
        reg_check(8'h4C, 8'h00, "R1 cfg reset");
        for (int i = 0; i < 4; i++) begin
            reg_check(8'h50 + i, 8'h00, "R1 pattern reset");
            reg_check(8'h54 + i, 8'h00, "R1 mask reset");
        end

        // R2: register map
        reg_write(8'h4C, 8'hFF);
        reg_check(8'h4C, 8'h7F, "R2 cfg bit7 read-only");
        reg_write(8'h52, 8'h3C);
        reg_write(8'h57, 8'hC3);
        reg_check(8'h52, 8'h3C, "R2 pattern byte3");
        reg_check(8'h57, 8'hC3, "R2 mask byte4");
        reg_check(8'h58, 8'h00, "R2 unmapped address");

        // R6: keep idle cells
        reg_write(8'h4C, 8'h00);
        for (int i = 0; i < 4; i++) begin
            reg_write(8'h50 + i, (i == 3) ? 8'h01 : 8'h00);
            reg_write(8'h54 + i, 8'hFF);
        end
        add_cell(32'h0000_0001, 1, -1);
        add_cell(32'h0000_0001, 2, -1);
        add_cell(32'h0000_0003, 3, -1);
        run_batch(159, 0, "R6 keep idle");

        // R5, R4: discard idle, last header byte decides, payload irrelevant
        reg_write(8'h4C, 8'h10);
        add_cell(32'h0000_0001, 4, -1);
        add_cell(32'h0000_0000, 5, -1);
        add_cell(32'h0000_0001, 9, -1);
        run_batch(53, 2, "R5 R4 discard idle");

        // R3: masked compare, header 0xA5 vs pattern 0xAD under mask 0xF0
        reg_write(8'h50, 8'hAD);
        reg_write(8'h54, 8'hF0);
        for (int i = 1; i < 4; i++) reg_write(8'h54 + i, 8'h00);
        add_cell(32'hA512_3456, 6, -1);
        add_cell(32'h5A12_3456, 7, -1);
        run_batch(53, 1, "R3 masked match");

        // R9: junk before a cell and stray in_sop inside a cell
        inq.push_back({1'b0, 8'hA5});
        inq.push_back({1'b0, 8'h11});
        inq.push_back({1'b0, 8'h22});
        add_cell(32'h5A00_0000, 8, 20);
        run_batch(53, 0, "R9 hunt and stray sop");

        // R10: a write in mid-cell applies from the next cell
        reg_write(8'h4C, 8'h00);
        trig_at = 2; trig_a = 8'h4C; trig_v = 8'h10;
        add_cell(32'hA500_0000, 10, -1);
        add_cell(32'hA5FF_FFFF, 11, -1);
        run_batch(53, 1, "R10 config at cell boundary");

        // R11: downstream backpressure
        bp_on = 1;
        for (int c = 0; c < 6; c++) add_cell((c % 2 == 0) ? 32'hA1B2_C3D4 : 32'h1122_3344, c + 20, -1);
        run_batch(159, 3, "R11 backpressure");
        bp_on = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule